// File: doc/BRIEF.md
# Single-Cell Charge Sequencer with Status Indication

This block is the digital sequencer of a single-cell battery charger. It watches digital condition flags that analog comparators elsewhere produce: supply valid, battery above the pre-charge level, battery above the top-up level, charge current below the taper minimum, a one-cycle expiry pulse from an external safety timer, and a die over-temperature flag. From these flags it decides whether charge current may flow. It also starts the safety timer again at the right moments and drives an active-low status line for an LED or a host input pin.

Charging runs from pre-charge into fast charge. When the battery is full and the current has tapered, the status line is released and stays released. Current still flows until the safety timer expires. If the timer expires while charging is still under way, the sequencer enters a fault. In the fault the status line blinks slowly, and only a loss of supply clears it. The status line passes through a debounce filter that runs on a millisecond tick, and the blink period is counted on the same tick.

Top module: `chg_status_ctrl`

## Requirements
- R1: While reset is active, and one cycle after `pwr_ok` goes low, the sequencer is idle: `chg_on`=0 and `tmr_clr`=0, and once the filter settles `stat_n`=1.
- R2: When `pwr_ok` rises from idle, the sequencer enters pre-charge if `bat_gt_pre`=0 and fast charge if `bat_gt_pre`=1. `tmr_clr` pulses high for exactly one cycle on that entry.
- R3: During pre-charge and fast charge, `chg_on`=1 and `stat_n`=0. Going from pre-charge to fast charge does not pulse `tmr_clr`.
- R4: Charge is complete only when `bat_gt_top`=1 and `i_lt_min`=1 in the same cycle. Either flag alone leaves the sequencer in fast charge. On completion `stat_n` returns to 1.
- R5: After completion, `stat_n` stays 1 when the current rises again. `chg_on` stays 1 until a `tmr_exp` pulse arrives, and then drops to 0.
- R6: When `bat_gt_top` falls, the sequencer goes back to fast charge (`stat_n`=0, `chg_on`=1). From the stopped state this pulses `tmr_clr` once. From the top-up state it does not.
- R7: A `tmr_exp` pulse during pre-charge or fast charge enters the fault state. There `chg_on`=0 and `stat_n` toggles every `BLINK_MS` ticks.
- R8: The fault state ignores every battery and current flag, and only `pwr_ok`=0 leaves it.
- R9: While `hot`=1, `chg_on`=0 and the state is frozen, so a `tmr_exp` pulse has no effect. When `hot` clears, the stored state resumes.
- R10: `stat_n` follows the internal status only after the status has been steady for `DG_MS` consecutive ticks, on both edges. One tick lasts `TICK_CYC` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Input supply is within its valid window |
| bat_gt_pre | input | 1 | Battery voltage above the pre-charge level |
| bat_gt_top | input | 1 | Battery voltage above the top-up level |
| i_lt_min | input | 1 | Charge current below the taper minimum |
| tmr_exp | input | 1 | One-cycle pulse: safety timer has expired |
| hot | input | 1 | Die over-temperature |
| stat_n | output | 1 | Debounced status, low while charging |
| chg_on | output | 1 | Allows the charge current path |
| tmr_clr | output | 1 | One-cycle pulse that clears the safety timer |

## Verification
One table walks a single charge cycle with the two completion flags raised one at a time and then together. This separates a design that completes on either flag alone from one that needs both. It also raises the current again after completion, which tells a latched status apart from one that tracks the flags. The table sends timer pulses while the die is hot, during top-up and during fast charge, so freezing, normal termination and fault entry each give a different `chg_on` result. The directed tests count blink edges in the fault, check that a battery drop cannot leave the fault, and show that a supply cycle that restarts straight into fast charge gives exactly one timer clear, with `stat_n` changing only after the filter delay.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PRE     = 3'd1,
    ST_FAST    = 3'd2,
    ST_TOPUP   = 3'd3,
    ST_STOPPED = 3'd4,
    ST_FAULT   = 3'd5
  } chg_state_e;

  // current flows in these states unless the die is hot
  function automatic logic state_charges(input chg_state_e s);
    return (s == ST_PRE) || (s == ST_FAST) || (s == ST_TOPUP);
  endfunction

  // undebounced active-low status level
  function automatic logic status_level_n(input chg_state_e s, input logic blink_ph);
    case (s)
      ST_PRE, ST_FAST: return 1'b0;
      ST_FAULT:        return blink_ph;
      default:         return 1'b1;
    endcase
  endfunction

  function automatic logic done_qualified(input logic top, input logic low_i);
    return top & low_i;
  endfunction

endpackage

// File: rtl/chg_tick_gen.sv
module chg_tick_gen #(
  parameter int TICK_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == LAST);

  generate
    if (TICK_CYC > 1) begin : g_chk
      assert_tick_isolated_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/chg_blink.sv
module chg_blink #(
  parameter int BLINK_MS = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic phase
);
  localparam int BW = (BLINK_MS > 1) ? $clog2(BLINK_MS) : 1;
  localparam logic [BW-1:0] LAST = BW'(BLINK_MS - 1);

  logic [BW-1:0] cnt_q;
  logic          ph_q;
  logic          half_done;

  assign half_done = tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (half_done) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase = ph_q;

  assert_phase_moves_on_tick_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$stable(ph_q)) |-> $past(tick));

endmodule

// File: rtl/chg_deglitch.sv
module chg_deglitch #(
  parameter int DG_MS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw_n,
  output logic filt_n
);
  localparam int DW = $clog2(DG_MS + 1);
  localparam logic [DW-1:0] LAST = DW'(DG_MS - 1);

  logic [DW-1:0] cnt_q;
  logic          out_q;
  logic          differs;

  assign differs = (raw_n != out_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        out_q <= raw_n;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_n = out_q;

  assert_out_follows_raw_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> (out_q == $past(raw_n)) && $past(tick));

endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
  import chg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       bat_gt_pre,
  input  logic       bat_gt_top,
  input  logic       i_lt_min,
  input  logic       tmr_exp,
  input  logic       hot,
  output chg_state_e state,
  output logic       restart_pulse
);
  chg_state_e st_q, st_d;
  logic       restart_d, restart_q;
  logic       fin_ok;

  assign fin_ok = done_qualified(bat_gt_top, i_lt_min);

  always_comb begin
    st_d      = st_q;
    restart_d = 1'b0;
    if (!pwr_ok) begin
      st_d = ST_IDLE;
    end else if (!hot) begin
      case (st_q)
        ST_IDLE: begin
          st_d      = bat_gt_pre ? ST_FAST : ST_PRE;
          restart_d = 1'b1;
        end
        ST_PRE: begin
          if (tmr_exp)         st_d = ST_FAULT;
          else if (bat_gt_pre) st_d = ST_FAST;
        end
        ST_FAST: begin
          if (tmr_exp)     st_d = ST_FAULT;
          else if (fin_ok) st_d = ST_TOPUP;
        end
        ST_TOPUP: begin
          if (tmr_exp)          st_d = ST_STOPPED;
          else if (!bat_gt_top) st_d = ST_FAST;
        end
        ST_STOPPED: begin
          if (!bat_gt_top) begin
            st_d      = ST_FAST;
            restart_d = 1'b1;
          end
        end
        ST_FAULT: st_d = ST_FAULT;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      restart_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      restart_q <= restart_d;
    end
  end

  assign state         = st_q;
  assign restart_pulse = restart_q;

  assert_supply_loss_idle_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (st_q == ST_IDLE));
  assert_restart_single_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |=> !restart_q);
  assert_done_needs_both_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAST && pwr_ok && !hot && !tmr_exp) |=>
      ((st_q == ST_TOPUP) == $past(bat_gt_top && i_lt_min)));
  assert_fault_sticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAULT && pwr_ok) |=> (st_q == ST_FAULT));
  assert_hot_freezes_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (hot && pwr_ok) |=> $stable(st_q));

endmodule

// File: rtl/chg_status_ctrl.sv
module chg_status_ctrl
  import chg_pkg::*;
#(
  parameter int TICK_CYC = 250000,
  parameter int DG_MS    = 1,
  parameter int BLINK_MS = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic bat_gt_pre,
  input  logic bat_gt_top,
  input  logic i_lt_min,
  input  logic tmr_exp,
  input  logic hot,
  output logic stat_n,
  output logic chg_on,
  output logic tmr_clr
);
  chg_state_e state;
  logic       tick;
  logic       blink_ph;
  logic       in_fault;
  logic       raw_stat_n;

  chg_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  chg_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .bat_gt_pre(bat_gt_pre),
    .bat_gt_top(bat_gt_top), .i_lt_min(i_lt_min), .tmr_exp(tmr_exp),
    .hot(hot), .state(state), .restart_pulse(tmr_clr)
  );

  assign in_fault = (state == ST_FAULT);

  chg_blink #(.BLINK_MS(BLINK_MS)) u_blink (
    .clk(clk), .rst_n(rst_n), .run(in_fault), .tick(tick), .phase(blink_ph)
  );

  assign raw_stat_n = status_level_n(state, blink_ph);

  chg_deglitch #(.DG_MS(DG_MS)) u_dg (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw_n(raw_stat_n), .filt_n(stat_n)
  );

  assign chg_on = state_charges(state) && !hot;

  assert_hot_no_current_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    hot |-> !chg_on);
  assert_fault_no_current_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    in_fault |-> !chg_on);
  assert_clr_only_on_start_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |-> (state == ST_PRE || state == ST_FAST));

endmodule

// File: tb/tb_chg_status_ctrl.sv
module tb_chg_status_ctrl;
  localparam int TICK = 20;
  localparam int DGM  = 2;
  localparam int BLM  = 3;
  localparam int SETTLE = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 0, bat_gt_pre = 0, bat_gt_top = 0, i_lt_min = 0, tmr_exp = 0, hot = 0;
  logic stat_n, chg_on, tmr_clr;

  int total = 0, bad = 0, clr_seen = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  chg_status_ctrl #(.TICK_CYC(TICK), .DG_MS(DGM), .BLINK_MS(BLM)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .bat_gt_pre(bat_gt_pre),
    .bat_gt_top(bat_gt_top), .i_lt_min(i_lt_min), .tmr_exp(tmr_exp), .hot(hot),
    .stat_n(stat_n), .chg_on(chg_on), .tmr_clr(tmr_clr)
  );

  always @(negedge clk) if (tmr_clr) clr_seen++;

  typedef struct packed {
    logic pg, pre, top, lowi, exp, ht;
    logic chk_st, st, en;
    logic [1:0] clr;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0, 2'd0}, // R1 idle
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 2'd1}, // R2 R3 pre-charge
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 2'd0}, // R3 fast
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 2'd0}, // R4 top only
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1, 2'd0}, // R4 low current only
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1, 2'd0}, // R4 both
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1, 2'd0}, // R5 latched
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0, 2'd0}, // R9 hot
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b0, 2'd0}, // R9 pulse ignored
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1, 2'd0}, // R9 resume top-up
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0, 2'd0}, // R5 stop on expiry
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 2'd1}, // R6 recharge from stop
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1, 2'd0}, // R4 complete again
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1, 2'd0}, // R6 recharge from top-up
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0, 2'd0}  // R7 fault entry
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    int toggles;
    logic prev;
    wait_cyc(3);
    // R1 reset state
    check("R1 reset stat_n", stat_n, 1'b1);
    check("R1 reset chg_on", chg_on, 1'b0);
    check("R1 reset tmr_clr", tmr_clr, 1'b0);
    rst_n = 1'b1;
    wait_cyc(2);

    for (int i = 0; i < 15; i++) begin
      base = clr_seen;
      pwr_ok = VEC[i].pg; bat_gt_pre = VEC[i].pre; bat_gt_top = VEC[i].top;
      i_lt_min = VEC[i].lowi; hot = VEC[i].ht; tmr_exp = VEC[i].exp;
      wait_cyc(1);
      tmr_exp = 1'b0;
      wait_cyc(SETTLE);
      if (VEC[i].chk_st) check($sformatf("row %0d stat_n", i), stat_n, VEC[i].st);
      check($sformatf("row %0d chg_on", i), chg_on, VEC[i].en);
      check_int($sformatf("row %0d tmr_clr count", i), clr_seen - base, int'(VEC[i].clr));
    end

    // R7 blink: half period BLM*TICK = 60 cycles, about 10 edges in 600
    toggles = 0;
    prev = stat_n;
    for (int c = 0; c < 600; c++) begin
      wait_cyc(1);
      if (stat_n !== prev) toggles++;
      prev = stat_n;
    end
    total++;
    if (toggles < 8 || toggles > 11) begin
      bad++;
      $display("FAIL R7 blink edges: actual=%0d expected=8..11", toggles);
    end

    // R8 battery drop does not leave the fault
    bat_gt_top = 1'b0; i_lt_min = 1'b0;
    wait_cyc(SETTLE);
    check("R8 fault holds chg_on", chg_on, 1'b0);
    check_int("R8 no timer clear in fault", clr_seen - base, 0);

    // R8 R1 supply loss clears the fault
    pwr_ok = 1'b0;
    wait_cyc(SETTLE);
    check("R1 idle stat_n", stat_n, 1'b1);
    check("R1 idle chg_on", chg_on, 1'b0);

    // R2 restart straight into fast charge, R10 filter delay
    base = clr_seen;
    bat_gt_pre = 1'b1;
    pwr_ok = 1'b1;
    wait_cyc(5);
    check("R2 fast start chg_on", chg_on, 1'b1);
    check("R10 stat_n not yet changed", stat_n, 1'b1);
    wait_cyc(SETTLE);
    check("R10 stat_n after filter", stat_n, 1'b0);
    check_int("R2 single timer clear", clr_seen - base, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule